// File: doc/BRIEF.md
# Paired-Page Translation Buffer with Software Management

This block holds a small, fully associative table of address translations. Each entry maps an even/odd pair of virtual pages to two physical frames and carries its own page-size mask, address-space ID, global flag and a hardware-invalid flag. The table is not consulted for live translation here. System software manages it through a set of coprocessor-style registers: a page-pair tag register, two frame descriptors, a page-mask register, an index register and a wired limit. The register file lives outside the block. It presents its current values on the `*_i` inputs and takes results back through the `*_we` strobes.

A command is issued by pulsing `start` for one cycle with an opcode on `op`. The block has two states. `ST_IDLE` waits for a command. The transition `ST_IDLE -> ST_REPLY` (named *accept*) commits the table update and registers the results in the same edge. `ST_REPLY` raises `done` for one cycle and then follows `ST_REPLY -> ST_IDLE` (named *retire*). A `start` seen in `ST_REPLY` is not accepted. Every command, including probe, therefore completes in the cycle after its start.

The commands are:
- probe, an associative search;
- indexed read;
- indexed write;
- write to a rotating victim slot that skips the wired entries;
- invalidate entries of one address space;
- invalidate every entry.

Top module: `tlbp_mmu`

## Requirements
- R1: After reset every entry is marked invalid and `done`, `index_we` and `regs_we` are low, so a probe issued straight after reset misses.
- R2: `op` codes are probe=0, read=1, indexed write=2, random write=3, invalidate-by-ID=4 and invalidate-all=5. `done` is a one-cycle pulse in the cycle after the `start` cycle. `index_we` accompanies `done` for probe only, and `regs_we` accompanies `done` for read only.
- R3: A write stores the tag from `hi_i[31:13]`, the ID from `hi_i[7:0]`, the mask from `mask_i[28:13]` and, for each frame descriptor, valid (bit 1), dirty (bit 2), attribute (bits 5:3) and frame number (bits 25:6). The entry's global flag is the AND of bit 0 of both descriptors.
- R4: A write with `hi_i[10]` set only marks the target entry invalid.
- R5: A probe matches an entry that is not invalid, whose tag equals `hi_i[31:13]` in every bit not set in that entry's stored mask, and that is either global or has an ID equal to `hi_i[7:0]`.
- R6: When several entries match, the probe returns the lowest index, with bit 31 clear.
- R7: A probe that finds no match returns `index_i` with bit 31 set.
- R8: Indexed read and indexed write use `index_i[30:0]` modulo the entry count.
- R9: Reading an invalid entry returns `hi_o` = 0x400 (only bit 10 set) and zero in `lo0_o`, `lo1_o` and `mask_o`.
- R10: Reading a valid entry returns tag and ID in `hi_o`, the mask in `mask_o[28:13]`, and both descriptors in the R3 layout with the global flag in bit 0 of each.
- R11: Invalidate-by-ID marks every non-global entry whose ID equals `hi_i[7:0]`. Global entries and entries with other IDs are kept.
- R12: Invalidate-all marks every entry invalid.
- R13: Random write targets a slot that starts at the last entry. The slot steps down by one after each random write, and after writing the slot equal to `wired_i` it wraps back to the last entry. A slot below `wired_i` is never chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Command strobe |
| op | input | 3 | Command code |
| hi_i | input | 32 | Page-pair tag register value |
| lo0_i | input | 32 | Even-page frame descriptor |
| lo1_i | input | 32 | Odd-page frame descriptor |
| mask_i | input | 32 | Page-mask register value |
| index_i | input | 32 | Index register value |
| wired_i | input | $clog2(ENTRIES) | Lowest slot eligible for random write |
| done | output | 1 | Command complete pulse |
| index_we | output | 1 | Index register update strobe |
| index_o | output | 32 | New index register value |
| regs_we | output | 1 | Tag/descriptor/mask update strobe |
| hi_o | output | 32 | New tag register value |
| lo0_o | output | 32 | New even descriptor |
| lo1_o | output | 32 | New odd descriptor |
| mask_o | output | 32 | New page-mask value |

## Verification
The bench builds the block with `ENTRIES = 8`, which makes `wired_i` three bits wide. With eight entries, index values such as 13 and 14 reach the modulo wrap. A full cycle of random writes with a wired limit of 2 wraps from slot 2 back to slot 7 within seven commands. The small table also lets a reference model in the bench follow every entry, so each probe can be checked for lowest-match priority and mask handling against all live entries.

// File: rtl/tlbp_pkg.sv
package tlbp_pkg;
    localparam int DW      = 32;
    localparam int ASID_W  = 8;
    localparam int INV_BIT = 10;
    localparam int TAG_LSB = 13;
    localparam int TAG_W   = DW - TAG_LSB;
    localparam int MASK_W  = 16;
    localparam int PFN_W   = 20;
    localparam int LO_PAD  = DW - 6 - PFN_W;
    localparam int PM_PAD  = DW - TAG_LSB - MASK_W;

    typedef enum logic [2:0] {
        OP_PROBE     = 3'd0,
        OP_READ      = 3'd1,
        OP_WRITE_IDX = 3'd2,
        OP_WRITE_RND = 3'd3,
        OP_INV_ASID  = 3'd4,
        OP_INV_ALL   = 3'd5
    } tlb_op_e;

    typedef struct packed {
        logic [PFN_W-1:0] pfn;
        logic [2:0]       attr;
        logic             dirty;
        logic             valid;
    } half_t;

    typedef struct packed {
        logic [TAG_W-1:0]  vtag;
        logic [ASID_W-1:0] asid;
        logic [MASK_W-1:0] mask;
        logic              glob;
        logic              dead;
        half_t             even;
        half_t             odd;
    } slot_t;
endpackage

// File: rtl/tlbp_store.sv
module tlbp_store
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [IW-1:0]      wr_idx,
    input  slot_t              wr_slot,
    input  logic               kill_asid_en,
    input  logic               kill_all_en,
    input  logic [ASID_W-1:0]  kill_asid,
    input  logic [TAG_W-1:0]   probe_tag,
    input  logic [ASID_W-1:0]  probe_asid,
    input  logic [IW-1:0]      rd_idx,
    output slot_t              rd_slot,
    output logic [ENTRIES-1:0] match_vec
);
    slot_t slots [ENTRIES];

    for (genvar i = 0; i < ENTRIES; i++) begin : g_ent
        slot_t ent_q;
        logic  kill_me;
        logic [TAG_W-1:0] care;

        assign kill_me = kill_all_en ||
                         (kill_asid_en && !ent_q.glob && ent_q.asid == kill_asid);

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ent_q      <= '0;
                ent_q.dead <= 1'b1;
            end else if (wr_en && wr_idx == IW'(i)) begin
                ent_q <= wr_slot;
            end else if (kill_me) begin
                ent_q.dead <= 1'b1;
            end
        end

        assign care         = ~{{(TAG_W-MASK_W){1'b0}}, ent_q.mask};
        assign match_vec[i] = !ent_q.dead &&
                              (ent_q.glob || ent_q.asid == probe_asid) &&
                              (((ent_q.vtag ^ probe_tag) & care) == '0);
        assign slots[i]     = ent_q;
    end

    assign rd_slot = slots[rd_idx];

    // R12
    kill_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        kill_all_en && !wr_en |=> match_vec == '0);

    // R4
    ehinv_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_slot.dead |=> !match_vec[$past(wr_idx)]);
endmodule

// File: rtl/tlbp_first.sv
module tlbp_first #(
    parameter int N  = 16,
    parameter int IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  vec,
    output logic          hit,
    output logic [IW-1:0] idx
);
    always_comb begin
        hit = |vec;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) idx = IW'(i);
        end
    end

    // R6
    lowest_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> vec[idx] && ((vec & ((N'(1) << idx) - N'(1))) == '0));
endmodule

// File: rtl/tlbp_victim.sv
module tlbp_victim #(
    parameter int ENTRIES = 16,
    parameter int IW      = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [IW-1:0] wired,
    output logic [IW-1:0] slot
);
    localparam logic [IW-1:0] LAST = IW'(ENTRIES - 1);

    logic [IW-1:0] cnt_q;

    assign slot = (cnt_q < wired) ? LAST : cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    cnt_q <= LAST;
        else if (step) cnt_q <= (slot <= wired) ? LAST : slot - 1'b1;
    end

    // R13
    above_wired_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wired <= LAST |-> slot >= wired && slot <= LAST);
endmodule

// File: rtl/tlbp_mmu.sv
module tlbp_mmu
    import tlbp_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IW     = $clog2(ENTRIES)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic [2:0]    op,
    input  logic [31:0]   hi_i,
    input  logic [31:0]   lo0_i,
    input  logic [31:0]   lo1_i,
    input  logic [31:0]   mask_i,
    input  logic [31:0]   index_i,
    input  logic [IW-1:0] wired_i,
    output logic          done,
    output logic          index_we,
    output logic [31:0]   index_o,
    output logic          regs_we,
    output logic [31:0]   hi_o,
    output logic [31:0]   lo0_o,
    output logic [31:0]   lo1_o,
    output logic [31:0]   mask_o
);
    typedef enum logic [0:0] {ST_IDLE, ST_REPLY} state_e;

    state_e state_q, state_d;
    logic   accept;
    logic   is_probe, is_read, is_wr_idx, is_wr_rnd, is_inv_id, is_inv_all;
    logic [IW-1:0] ind_idx, tgt_idx, victim_slot, hit_idx;
    logic          hit;
    logic [ENTRIES-1:0] match_vec;
    slot_t rd_slot, wr_slot;

    logic unused_bits;
    assign unused_bits = ^{hi_i[12:11], hi_i[9:8], lo0_i[31:26], lo1_i[31:26],
                           mask_i[31:29], mask_i[12:0]};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start) state_d = ST_REPLY;
            ST_REPLY: state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    assign accept     = (state_q == ST_IDLE) && start;
    assign is_probe   = op == OP_PROBE;
    assign is_read    = op == OP_READ;
    assign is_wr_idx  = op == OP_WRITE_IDX;
    assign is_wr_rnd  = op == OP_WRITE_RND;
    assign is_inv_id  = op == OP_INV_ASID;
    assign is_inv_all = op == OP_INV_ALL;

    assign ind_idx = IW'(index_i[DW-2:0] % (DW-1)'(ENTRIES));
    assign tgt_idx = is_wr_rnd ? victim_slot : ind_idx;

    always_comb begin
        if (hi_i[INV_BIT]) begin
            wr_slot      = rd_slot;
            wr_slot.dead = 1'b1;
        end else begin
            wr_slot.vtag  = hi_i[DW-1:TAG_LSB];
            wr_slot.asid  = hi_i[ASID_W-1:0];
            wr_slot.mask  = mask_i[TAG_LSB+MASK_W-1:TAG_LSB];
            wr_slot.glob  = lo0_i[0] & lo1_i[0];
            wr_slot.dead  = 1'b0;
            wr_slot.even  = half_t'(lo0_i[6+PFN_W-1:1]);
            wr_slot.odd   = half_t'(lo1_i[6+PFN_W-1:1]);
        end
    end

    tlbp_store #(.ENTRIES(ENTRIES), .IW(IW)) u_store (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (accept && (is_wr_idx || is_wr_rnd)),
        .wr_idx       (tgt_idx),
        .wr_slot      (wr_slot),
        .kill_asid_en (accept && is_inv_id),
        .kill_all_en  (accept && is_inv_all),
        .kill_asid    (hi_i[ASID_W-1:0]),
        .probe_tag    (hi_i[DW-1:TAG_LSB]),
        .probe_asid   (hi_i[ASID_W-1:0]),
        .rd_idx       (tgt_idx),
        .rd_slot      (rd_slot),
        .match_vec    (match_vec)
    );

    tlbp_first #(.N(ENTRIES), .IW(IW)) u_first (
        .clk   (clk),
        .rst_n (rst_n),
        .vec   (match_vec),
        .hit   (hit),
        .idx   (hit_idx)
    );

    tlbp_victim #(.ENTRIES(ENTRIES), .IW(IW)) u_victim (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (accept && is_wr_rnd),
        .wired (wired_i),
        .slot  (victim_slot)
    );

    // output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done     <= 1'b0;
            index_we <= 1'b0;
            regs_we  <= 1'b0;
            index_o  <= '0;
            hi_o     <= '0;
            lo0_o    <= '0;
            lo1_o    <= '0;
            mask_o   <= '0;
        end else begin
            done     <= accept;
            index_we <= accept && is_probe;
            regs_we  <= accept && is_read;
            if (accept && is_probe) begin
                index_o <= hit ? {{(DW-IW){1'b0}}, hit_idx}
                               : (index_i | 32'h8000_0000);
            end
            if (accept && is_read) begin
                if (rd_slot.dead) begin
                    hi_o   <= 32'(1) << INV_BIT;
                    lo0_o  <= '0;
                    lo1_o  <= '0;
                    mask_o <= '0;
                end else begin
                    hi_o   <= {rd_slot.vtag, {(TAG_LSB-ASID_W){1'b0}}, rd_slot.asid};
                    lo0_o  <= {{LO_PAD{1'b0}}, rd_slot.even, rd_slot.glob};
                    lo1_o  <= {{LO_PAD{1'b0}}, rd_slot.odd, rd_slot.glob};
                    mask_o <= {{PM_PAD{1'b0}}, rd_slot.mask, {TAG_LSB{1'b0}}};
                end
            end
        end
    end

    // R2
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(start));

    // R9
    dead_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_we && hi_o[INV_BIT] |-> lo0_o == '0 && lo1_o == '0 && mask_o == '0);

    // R10
    glob_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        regs_we |-> lo0_o[0] == lo1_o[0]);

    // R6
    probe_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        index_we && !index_o[31] |-> index_o[30:0] < 31'(ENTRIES));
endmodule

// File: tb/tb_tlbp_mmu.sv
module tb_tlbp_mmu;
    localparam int N  = 8;
    localparam int IW = $clog2(N);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [2:0] op = '0;
    logic [31:0] hi_i = '0, lo0_i = '0, lo1_i = '0, mask_i = '0, index_i = '0;
    logic [IW-1:0] wired_i = '0;
    logic done, index_we, regs_we;
    logic [31:0] index_o, hi_o, lo0_o, lo1_o, mask_o;

    always #10 clk = ~clk;

    tlbp_mmu #(.ENTRIES(N)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .op(op),
        .hi_i(hi_i), .lo0_i(lo0_i), .lo1_i(lo1_i), .mask_i(mask_i),
        .index_i(index_i), .wired_i(wired_i),
        .done(done), .index_we(index_we), .index_o(index_o),
        .regs_we(regs_we), .hi_o(hi_o), .lo0_o(lo0_o), .lo1_o(lo1_o),
        .mask_o(mask_o)
    );

    typedef struct {
        string       req;
        bit          is_probe;
        bit          is_read;
        logic [31:0] idx, hi, lo0, lo1, pm;
    } exp_t;

    exp_t sb[$];
    int checks = 0;
    int fails  = 0;

    // reference table
    logic [31:0] m_hi [N];
    logic [31:0] m_lo0[N];
    logic [31:0] m_lo1[N];
    logic [31:0] m_pm [N];
    bit          m_g  [N];
    bit          m_dead[N];
    int          m_cnt;

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_up();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    task automatic issue(input logic [2:0] c, input logic [31:0] hi, input logic [31:0] l0,
                         input logic [31:0] l1, input logic [31:0] pm, input logic [31:0] ix,
                         input int wd, input string req);
        exp_t e;
        int   t;
        int   hit;
        e.req = req; e.is_probe = (c == 3'd0); e.is_read = (c == 3'd1);
        e.idx = 0; e.hi = 0; e.lo0 = 0; e.lo1 = 0; e.pm = 0;
        t = int'(ix[30:0] % 31'(N));
        case (c)
            3'd0: begin
                hit = -1;
                for (int i = N - 1; i >= 0; i--)
                    if (!m_dead[i] && (m_g[i] || m_hi[i][7:0] == hi[7:0]) &&
                        (((m_hi[i] ^ hi) & 32'hFFFF_E000 & ~m_pm[i]) == 0)) hit = i;
                e.idx = (hit < 0) ? (ix | 32'h8000_0000) : 32'(hit);
            end
            3'd1: begin
                if (m_dead[t]) e.hi = 32'h400;
                else begin
                    e.hi = m_hi[t]; e.lo0 = m_lo0[t]; e.lo1 = m_lo1[t]; e.pm = m_pm[t];
                end
            end
            3'd2, 3'd3: begin
                if (c == 3'd3) begin
                    t = (m_cnt < wd) ? N - 1 : m_cnt;
                    m_cnt = (t <= wd) ? N - 1 : t - 1;
                end
                if (hi[10]) m_dead[t] = 1'b1;
                else begin
                    m_dead[t] = 1'b0;
                    m_g[t]    = l0[0] & l1[0];
                    m_hi[t]   = hi & 32'hFFFF_E0FF;
                    m_lo0[t]  = (l0 & 32'h03FF_FFFE) | 32'(m_g[t]);
                    m_lo1[t]  = (l1 & 32'h03FF_FFFE) | 32'(m_g[t]);
                    m_pm[t]   = pm & 32'h1FFF_E000;
                end
            end
            3'd4: for (int i = 0; i < N; i++)
                      if (!m_g[i] && m_hi[i][7:0] == hi[7:0]) m_dead[i] = 1'b1;
            3'd5: for (int i = 0; i < N; i++) m_dead[i] = 1'b1;
            default: ;
        endcase
        sb.push_back(e);
        @(posedge clk); #2;
        start = 1'b1; op = c; hi_i = hi; lo0_i = l0; lo1_i = l1; mask_i = pm;
        index_i = ix; wired_i = IW'(wd);
        @(posedge clk); #2;
        start = 1'b0;
    endtask

    task automatic probe(input logic [31:0] hi, input logic [31:0] ix, input string req);
        issue(3'd0, hi, 0, 0, 0, ix, 0, req);
    endtask

    task automatic rd(input logic [31:0] ix, input string req);
        issue(3'd1, 0, 0, 0, 0, ix, 0, req);
    endtask

    task automatic wr(input logic [31:0] hi, input logic [31:0] l0, input logic [31:0] l1,
                      input logic [31:0] pm, input logic [31:0] ix, input string req);
        issue(3'd2, hi, l0, l1, pm, ix, 0, req);
    endtask

    // monitor: pops one expected item per done pulse
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                exp_t e;
                if (sb.size() == 0) begin
                    checks++; fails++;
                    $display("FAIL R2: done with no pending command, got 1 expected 0");
                end else begin
                    e = sb.pop_front();
                    check({e.req, " R2 index_we"}, 32'(index_we), 32'(e.is_probe));
                    check({e.req, " R2 regs_we"}, 32'(regs_we), 32'(e.is_read));
                    if (e.is_probe) check({e.req, " index"}, index_o, e.idx);
                    if (e.is_read) begin
                        check({e.req, " hi"}, hi_o, e.hi);
                        check({e.req, " lo0"}, lo0_o, e.lo0);
                        check({e.req, " lo1"}, lo1_o, e.lo1);
                        check({e.req, " mask"}, mask_o, e.pm);
                    end
                end
            end
        end
    end

    initial begin
        #(20 * 200000);
        checks++; fails++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_up();
    end

    initial begin
        for (int i = 0; i < N; i++) begin
            m_hi[i] = 0; m_lo0[i] = 0; m_lo1[i] = 0; m_pm[i] = 0; m_g[i] = 0; m_dead[i] = 1;
        end
        m_cnt = N - 1;
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        check("R1 done", 32'(done), 0);
        check("R1 index_we", 32'(index_we), 0);
        check("R1 regs_we", 32'(regs_we), 0);

        probe(32'h1234_6005, 32'h0, "R1 R7 probe after reset");
        // R3 global entry and R10 read-back
        wr(32'h1234_6005, 32'h0000_1017, 32'h0000_2057, 0, 0, "R3 write global");
        rd(0, "R10 read global");
        wr(32'h1234_6005, 32'h0000_1017, 32'h0000_2056, 0, 1, "R3 write non-global");
        rd(1, "R3 R10 read non-global");
        probe(32'h1234_6009, 0, "R5 global any id");
        probe(32'h1234_6005, 0, "R6 lowest of two");
        // R6 duplicate tags
        wr(32'h0ABC_0003, 32'h0000_0042, 32'h0000_0082, 0, 3, "R3 dup A");
        wr(32'h0ABC_0003, 32'h0000_0042, 32'h0000_0082, 0, 5, "R3 dup B");
        probe(32'h0ABC_0003, 0, "R6 lowest index");
        probe(32'h0ABC_0004, 32'h2, "R5 R7 id mismatch");
        // R5 mask
        wr(32'h5000_2003, 32'h2, 32'h4, 32'h0000_6000, 2, "R3 masked entry");
        probe(32'h5000_4003, 0, "R5 masked bit ignored");
        probe(32'h5000_8003, 32'h5, "R5 R7 unmasked bit differs");
        rd(2, "R10 mask readback");
        // R8 modulo
        rd(32'h8000_000D, "R8 read wraps");
        wr(32'h6600_0003, 32'h3, 32'h3, 0, 32'h0000_000E, "R8 write wraps");
        rd(6, "R8 wrapped write landed");
        // R4 and R9
        wr(32'h0ABC_0403, 32'h0, 32'h0, 0, 3, "R4 invalidating write");
        probe(32'h0ABC_0003, 0, "R4 probe skips invalid");
        rd(3, "R9 read invalid");
        // R11
        wr(32'h7777_E003, 32'h1, 32'h1, 0, 7, "R3 global id 3");
        issue(3'd4, 32'h0000_0003, 0, 0, 0, 0, 0, "R11 inv id 3");
        probe(32'h7777_E003, 0, "R11 global kept");
        probe(32'h0ABC_0003, 0, "R11 id 3 gone");
        probe(32'h1234_6005, 0, "R11 other id kept");
        rd(2, "R11 R9 killed entry");
        // R13
        for (int k = 0; k < 7; k++)
            issue(3'd3, 32'(k + 1) << 24 | 32'h1, 32'h1, 32'h1, 0, 0, 2, "R13 random write");
        for (int k = 1; k < 7; k++)
            probe(32'(k + 1) << 24 | 32'h1, 0, "R13 victim slot");
        rd(7, "R13 wrapped slot");
        // R12
        issue(3'd5, 0, 0, 0, 0, 0, 0, "R12 inv all");
        probe(32'h0700_0001, 32'h3, "R12 probe after inv all");
        rd(0, "R12 read after inv all");
        repeat (4) @(posedge clk);
        check("R2 scoreboard drained", 32'(sb.size()), 0);
        finish_up();
    end
endmodule